// File: doc/BRIEF.md
# Byte-Wide Chained Configuration Loader

This block is the configuration-load front end of a programmable device that takes its setup data one byte per edge of an externally driven configuration clock. Several identical devices share that clock and the byte bus. Each device's status output feeds the enable input of the next device in the chain. A device listens only while its enable is high. It searches the bus for a two-byte preamble and then writes the following frame bytes into its configuration memory through a simple write port.

After every frame of data bytes comes a fixed stop code. This code is the only integrity check, because the loader keeps no length count and computes no CRC. When the last frame's stop code is accepted, the loader raises done and drives its status output high again. The next device then takes the following preamble and data from the shared bus. A wrong stop code freezes the loader and raises a sticky error flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `chain_ok_o` is 1, `done_o`, `err_o` and `mem_we_o` are 0, and the write address restarts at 0.
- R2: The first rising edge at which the loader is enabled only primes it and samples no byte. From the second such consecutive edge on, one byte is sampled at every rising edge.
- R3: A byte present while `chain_en_i` is low is ignored. When the enable returns, the first edge primes again (R2) before any byte is sampled.
- R4: Loading is selected only when `mode_sel[1]` is 0, and `mode_sel[0]` has no effect. When `mode_sel[1]` is 1, no write occurs and `chain_ok_o` stays 1.
- R5: The header is 0xFF followed by 0xA5. Bytes before the header are ignored, and extra 0xFF bytes before 0xA5 are allowed. `chain_ok_o` falls at the edge that samples the 0xA5.
- R6: Every byte sampled after the header, other than a stop code, drives `mem_we_o` high for one cycle from the sampling edge. `mem_data_o` carries the byte and `mem_addr_o` counts up from 0 by one per write.
- R7: After every FRAME_BYTES data bytes, the next sampled byte must be the stop code 0x00. It is not written, and loading of the next frame then continues.
- R8: A wrong stop code sets `err_o` at that edge. `err_o` stays set until reset, no further writes occur, `chain_ok_o` stays 0 and `done_o` stays 0.
- R9: When the stop code of frame FRAMES is accepted, `done_o` and `chain_ok_o` go to 1 at that edge and stay there. All later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Shared configuration byte bus |
| chain_en_i | input | 1 | Enable from the previous device; tie high on the first device |
| mode_sel | input | 2 | Mode pins; bit 1 = 0 selects byte loading |
| chain_ok_o | output | 1 | Status to the next device's enable: low from header until memory full |
| done_o | output | 1 | Configuration complete |
| err_o | output | 1 | Sticky stop-code mismatch flag |
| mem_we_o | output | 1 | Configuration memory write strobe |
| mem_addr_o | output | $clog2(FRAMES*FRAME_BYTES) | Configuration memory write address |
| mem_data_o | output | 8 | Configuration memory write data |

## Verification
The assertions assume that `cfg_byte`, `chain_en_i` and `mode_sel` change only between rising edges and hold steady across each edge. They also assume that reset is applied before the first byte, so that past values seen after release are defined. The bench drives every input at the falling edge and starts each scenario from a reset, which keeps the stimulus within those limits. Enable gaps and mode changes fall only on falling edges, so each one reaches a whole number of sampling edges.

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int          FRAMES      = 4,
  parameter int          FRAME_BYTES = 4,
  parameter logic [7:0]  PRE_A       = 8'hFF,
  parameter logic [7:0]  PRE_B       = 8'hA5,
  parameter logic [7:0]  STOP_CODE   = 8'h00
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [7:0]                               cfg_byte,
  input  logic                                     chain_en_i,
  input  logic [1:0]                               mode_sel,
  output logic                                     chain_ok_o,
  output logic                                     done_o,
  output logic                                     err_o,
  output logic                                     mem_we_o,
  output logic [$clog2(FRAMES*FRAME_BYTES)-1:0]    mem_addr_o,
  output logic [7:0]                               mem_data_o
);
  localparam int DEPTH = FRAMES * FRAME_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;

  typedef enum logic [2:0] {SEEK_A, SEEK_B, LOAD, TAIL, FINISHED, HALTED} st_t;

  st_t            st;
  logic           arm;
  logic [CW-1:0]  wr_cnt;
  logic [BW-1:0]  fb_cnt;

  logic active, sample;
  assign active = chain_en_i && !mode_sel[1] && (st != FINISHED) && (st != HALTED);
  assign sample = active && arm;
  assign done_o = (st == FINISHED);
  assign err_o  = (st == HALTED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SEEK_A;
      arm        <= 1'b0;
      wr_cnt     <= '0;
      fb_cnt     <= '0;
      chain_ok_o <= 1'b1;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      arm      <= active;
      mem_we_o <= 1'b0;
      if (sample) begin
        case (st)
          SEEK_A: if (cfg_byte == PRE_A) st <= SEEK_B;
          SEEK_B: begin
            if (cfg_byte == PRE_B) begin
              st         <= LOAD;
              chain_ok_o <= 1'b0;
            end else if (cfg_byte != PRE_A) begin
              st <= SEEK_A;
            end
          end
          LOAD: begin
            mem_we_o   <= 1'b1;
            mem_addr_o <= wr_cnt[AW-1:0];
            mem_data_o <= cfg_byte;
            wr_cnt     <= wr_cnt + 1'b1;
            if (fb_cnt == BW'(FRAME_BYTES - 1)) begin
              fb_cnt <= '0;
              st     <= TAIL;
            end else begin
              fb_cnt <= fb_cnt + 1'b1;
            end
          end
          TAIL: begin
            if (cfg_byte != STOP_CODE) begin
              st <= HALTED;
            end else if (wr_cnt == CW'(DEPTH)) begin
              st         <= FINISHED;
              chain_ok_o <= 1'b1;
            end else begin
              st <= LOAD;
            end
          end
          default: st <= st;
        endcase
      end
    end
  end

  assert_prime_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($past(chain_en_i) && $past(chain_en_i, 2)));

  assert_en_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(chain_en_i));

  assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !$past(mode_sel[1]));

  assert_hdr_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_ok_o) |-> ($past(cfg_byte) == PRE_B));

  assert_wr_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_data_o == $past(cfg_byte)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && !mem_we_o && !chain_ok_o && !done_o));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && chain_ok_o && !mem_we_o));

endmodule

// File: tb/cfg_byte_loader_tb.sv
`timescale 1ns/1ps
module cfg_byte_loader_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic       chain_en_i = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic       chain_ok_o, done_o, err_o, mem_we_o;
  logic [3:0] mem_addr_o;
  logic [7:0] mem_data_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cfg_byte_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .chain_en_i(chain_en_i),
    .mode_sel(mode_sel), .chain_ok_o(chain_ok_o), .done_o(done_o), .err_o(err_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
  );

  // {byte, expected write, expected chain_ok after the sampling edge}
  localparam logic [9:0] VEC [28] = '{
    {8'h12,2'b01}, {8'hFF,2'b01}, {8'h33,2'b01}, {8'hFF,2'b01}, {8'hFF,2'b01}, {8'hA5,2'b00},
    {8'h11,2'b10}, {8'hFF,2'b10}, {8'hA5,2'b10}, {8'h00,2'b10}, {8'h00,2'b00},
    {8'h21,2'b10}, {8'h22,2'b10}, {8'h23,2'b10}, {8'h24,2'b10}, {8'h00,2'b00},
    {8'h31,2'b10}, {8'h32,2'b10}, {8'h33,2'b10}, {8'h34,2'b10}, {8'h00,2'b00},
    {8'h41,2'b10}, {8'h42,2'b10}, {8'h43,2'b10}, {8'h44,2'b10}, {8'h00,2'b01},
    {8'h77,2'b01}, {8'hFF,2'b01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cfg_byte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    chain_en_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start();
    @(negedge clk);
    chain_en_i = 1'b1;
    @(posedge clk);
    #1;
    chk(mem_we_o == 1'b0, "R2 prime", mem_we_o, 0);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp_addr;
    do_reset();
    #1;
    chk(chain_ok_o == 1'b1, "R1 status", chain_ok_o, 1);
    chk(done_o == 1'b0 && err_o == 1'b0, "R1 flags", {done_o, err_o}, 0);
    chk(mem_we_o == 1'b0, "R1 we", mem_we_o, 0);

    mode_sel = 2'b01;
    start();
    exp_addr = 0;
    for (int i = 0; i < 28; i++) begin
      send(VEC[i][9:2]);
      chk(mem_we_o == VEC[i][1], "R6 we", mem_we_o, VEC[i][1]);
      chk(chain_ok_o == VEC[i][0], "R5 status", chain_ok_o, VEC[i][0]);
      if (VEC[i][1]) begin
        chk(mem_addr_o == 4'(exp_addr), "R6 addr", mem_addr_o, exp_addr);
        chk(mem_data_o == VEC[i][9:2], "R6 data", mem_data_o, VEC[i][9:2]);
        exp_addr++;
      end
    end
    chk(done_o == 1'b1, "R9 done", done_o, 1);
    chk(err_o == 1'b0, "R7 no error on good stops", err_o, 0);

    do_reset();
    start();
    send(8'hFF); send(8'hA5); send(8'h61);
    chk(mem_we_o && mem_addr_o == 4'd0, "R6 first", mem_addr_o, 0);
    @(negedge clk);
    chain_en_i = 1'b0;
    cfg_byte = 8'h62;
    @(posedge clk); #1;
    chk(mem_we_o == 1'b0, "R3 disabled", mem_we_o, 0);
    @(negedge clk);
    chain_en_i = 1'b1;
    cfg_byte = 8'h63;
    @(posedge clk); #1;
    chk(mem_we_o == 1'b0, "R3 reprime", mem_we_o, 0);
    send(8'h63);
    chk(mem_we_o && mem_addr_o == 4'd1 && mem_data_o == 8'h63, "R3 resume", mem_addr_o, 1);

    do_reset();
    mode_sel = 2'b10;
    start();
    send(8'hFF); send(8'hA5); send(8'h55);
    chk(mem_we_o == 1'b0, "R4 mode off we", mem_we_o, 0);
    chk(chain_ok_o == 1'b1, "R4 mode off status", chain_ok_o, 1);
    mode_sel = 2'b00;

    do_reset();
    start();
    send(8'hFF); send(8'hA5);
    send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    send(8'h5A);
    chk(err_o == 1'b1, "R8 err set", err_o, 1);
    send(8'h00); send(8'h11);
    chk(mem_we_o == 1'b0, "R8 no write", mem_we_o, 0);
    chk(err_o == 1'b1 && done_o == 1'b0, "R8 sticky", {err_o, done_o}, 2);
    chk(chain_ok_o == 1'b0, "R8 status low", chain_ok_o, 0);

    do_reset();
    #1;
    chk(err_o == 1'b0 && chain_ok_o == 1'b1, "R1 clear", {err_o, chain_ok_o}, 1);
    start();
    send(8'hFF); send(8'hA5); send(8'h99);
    chk(mem_we_o && mem_addr_o == 4'd0, "R1 addr restart", mem_addr_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule